// File: doc/BRIEF.md
# Self-Test Error Capture Register

This block sits beside a memory self-test engine and records what the comparison stage reports. On each cycle where the compare-valid strobe is high and the mismatch vector is nonzero, it merges the failing data bit positions into a 64-bit error vector. It also records the index of the data string that failed and a mask of the checker units that flagged the error. A small register write port sets three control bits: inhibit-clear at bit 2, clear at bit 1 and lock at bit 0. The test engine supplies two mode flags and three strobes: a phase-restart strobe, the compare-valid strobe with its data, and a continue pulse.

The capture policy depends on the mode. In free-run mode the record either builds up across passes or is wiped at each phase restart, as the inhibit-clear bit selects. In pause-on-error mode the first error raises a halt request. Without lock, later errors keep merging into the record. With lock, the first failure is frozen until software clears it. When both mode flags are high, pause-on-error takes precedence.

The control state machine has four states. RUN captures freely. HALT_OPEN is halted and still merging. HALT_FROZEN is halted with the record frozen. FROZEN has been resumed but the record stays frozen. The transitions are:
- RUN to HALT_OPEN on a pause-mode error with lock clear.
- RUN to HALT_FROZEN on a pause-mode error with lock set.
- HALT_OPEN to RUN on continue.
- HALT_FROZEN to FROZEN on continue alone.
- HALT_FROZEN to HALT_OPEN on a clear alone.
- HALT_FROZEN to RUN on continue and clear together.
- FROZEN to RUN on a clear.

Top module: `selftest_err_capture`

## Requirements
- R1: After reset the error vector, string field, checker mask, halt request and read-back control bits are all zero.
- R2: Inhibit-clear (bit 2) and lock (bit 0) are read/write. The clear bit (bit 1) always reads back as 0.
- R3: Writing 1 to the clear bit zeroes the error vector, string field and checker mask on the next cycle, even if a mismatch arrives in that same cycle.
- R4: A mismatch is captured only when compare-valid is high and the mismatch vector is nonzero. Capture ORs in the data bits and the checker mask, and the string field takes the failing string index.
- R5: In free-run mode with inhibit-clear at 0, a phase-restart strobe zeroes the record, and it wins over a mismatch in the same cycle.
- R6: In free-run mode with inhibit-clear at 1, a phase restart leaves the record alone and new mismatches keep merging.
- R7: In pause-on-error mode an error raises halt_req on the next cycle, and halt_req stays high until a continue pulse.
- R8: In pause-on-error mode without lock, mismatches arriving before any clear are ORed into the held record, both during the halt and after continuing.
- R9: In pause-on-error mode with lock set, the first error freezes the record. Later errors change nothing and raise no new halt until a clear.
- R10: Control bits outside their intended mode have no effect. Lock outside pause mode just accumulates. Phase restart outside free-run mode does not clear. With both mode flags high, the block behaves as pause mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Control register write enable |
| cfg_wdata | input | 3 | Control write data {inhibit, clear, lock} |
| cfg_rdata | output | 3 | Control read-back; the clear bit reads 0 |
| free_run | input | 1 | Free-run mode flag |
| pause_on_err | input | 1 | Pause-on-error mode flag |
| phase_restart | input | 1 | Strobe: self-test re-enters start-execution phase |
| cmp_valid | input | 1 | Compare result valid strobe |
| cmp_mismatch | input | 64 | Failing data bit positions |
| cmp_string | input | 3 | Index of the data string under compare |
| cmp_checker | input | 4 | Mask of checker units that flagged the mismatch |
| continue_pulse | input | 1 | Resume after a pause halt |
| halt_req | output | 1 | Halt request to the test engine |
| err_bits | output | 64 | Captured failing data bits |
| err_string | output | 3 | Captured failing string index |
| err_checker | output | 4 | Captured checker mask |

## Verification
The state machine is visible at the ports only through halt_req and whether err_bits keeps changing. A state that is wrongly frozen shows up one cycle after the next valid mismatch, when err_bits fails to grow. A state that is wrongly left open shows up as a changed record after a later error. A halt that drops early, or never rises, shows in the cycle right after the error or the continue pulse. The bench therefore places each error, continue and clear against an immediate read of all four outputs. It also places same-cycle collisions: clear against mismatch, restart against mismatch, and continue against clear.

// File: rtl/stec_pkg.sv
package stec_pkg;
    localparam int CFG_W    = 3;
    localparam int CFG_INH  = 2;
    localparam int CFG_CLR  = 1;
    localparam int CFG_LOCK = 0;

    typedef enum logic [1:0] {
        ST_RUN         = 2'd0,
        ST_HALT_OPEN   = 2'd1,
        ST_HALT_FROZEN = 2'd2,
        ST_FROZEN      = 2'd3
    } cap_state_t;
endpackage

// File: rtl/stec_cfg.sv
module stec_cfg
    import stec_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [CFG_W-1:0] wdata,
    output logic             inh_q,
    output logic             lock_q,
    output logic             clr_pulse,
    output logic [CFG_W-1:0] rdata
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            inh_q  <= 1'b0;
            lock_q <= 1'b0;
        end else if (we) begin
            inh_q  <= wdata[CFG_INH];
            lock_q <= wdata[CFG_LOCK];
        end
    end

    assign clr_pulse = we & wdata[CFG_CLR];

    always_comb begin
        rdata           = '0;
        rdata[CFG_INH]  = inh_q;
        rdata[CFG_LOCK] = lock_q;
    end
endmodule

// File: rtl/stec_fsm.sv
module stec_fsm
    import stec_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic err,
    input  logic pause_mode,
    input  logic lock_q,
    input  logic clr_any,
    input  logic cont,
    output logic take,
    output logic frozen,
    output logic halt_req
);
    cap_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    always_comb begin
        frozen = (state_q == ST_HALT_FROZEN) || (state_q == ST_FROZEN);
        take   = err && !clr_any && !frozen;
        state_d = state_q;
        unique case (state_q)
            ST_RUN: begin
                if (take && pause_mode)
                    state_d = lock_q ? ST_HALT_FROZEN : ST_HALT_OPEN;
            end
            ST_HALT_OPEN: begin
                if (cont) state_d = ST_RUN;
            end
            ST_HALT_FROZEN: begin
                if (cont && clr_any)  state_d = ST_RUN;
                else if (cont)        state_d = ST_FROZEN;
                else if (clr_any)     state_d = ST_HALT_OPEN;
            end
            ST_FROZEN: begin
                if (clr_any) state_d = ST_RUN;
            end
            default: state_d = ST_RUN;
        endcase
    end

    always_comb begin
        halt_req = (state_q == ST_HALT_OPEN) || (state_q == ST_HALT_FROZEN);
    end

    assert_halt_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (halt_req && !cont) |=> halt_req);
    assert_halt_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(halt_req) |-> $past(pause_mode && err));
    assert_frozen_no_halt_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FROZEN && !clr_any) |=> !halt_req);
endmodule

// File: rtl/stec_capture.sv
module stec_capture #(
    parameter int DATA_W = 64,
    parameter int STR_W  = 3,
    parameter int CHK_W  = 4,
    parameter int LANE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              take,
    input  logic [DATA_W-1:0] data,
    input  logic [STR_W-1:0]  str,
    input  logic [CHK_W-1:0]  chk,
    output logic [DATA_W-1:0] bits_q,
    output logic [STR_W-1:0]  str_q,
    output logic [CHK_W-1:0]  chk_q
);
    localparam int LANES = DATA_W / LANE_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        always_ff @(posedge clk) begin
            if (!rst_n || clr)
                bits_q[g*LANE_W +: LANE_W] <= '0;
            else if (take)
                bits_q[g*LANE_W +: LANE_W] <= bits_q[g*LANE_W +: LANE_W] | data[g*LANE_W +: LANE_W];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            str_q <= '0;
            chk_q <= '0;
        end else if (take) begin
            str_q <= str;
            chk_q <= chk_q | chk;
        end
    end

    assert_clear_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (bits_q == '0 && str_q == '0 && chk_q == '0));
    assert_accumulate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> ((bits_q & $past(bits_q)) == $past(bits_q)));
endmodule

// File: rtl/selftest_err_capture.sv
module selftest_err_capture
    import stec_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int STR_W  = 3,
    parameter int CHK_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CFG_W-1:0]  cfg_wdata,
    output logic [CFG_W-1:0]  cfg_rdata,
    input  logic              free_run,
    input  logic              pause_on_err,
    input  logic              phase_restart,
    input  logic              cmp_valid,
    input  logic [DATA_W-1:0] cmp_mismatch,
    input  logic [STR_W-1:0]  cmp_string,
    input  logic [CHK_W-1:0]  cmp_checker,
    input  logic              continue_pulse,
    output logic              halt_req,
    output logic [DATA_W-1:0] err_bits,
    output logic [STR_W-1:0]  err_string,
    output logic [CHK_W-1:0]  err_checker
);
    logic inh_q, lock_q, clr_pulse;
    logic pause_mode, free_mode, restart_clr, clr_any, err, take, frozen;

    stec_cfg u_cfg (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .wdata(cfg_wdata),
        .inh_q(inh_q), .lock_q(lock_q), .clr_pulse(clr_pulse), .rdata(cfg_rdata)
    );

    always_comb begin
        pause_mode  = pause_on_err;
        free_mode   = free_run && !pause_on_err;
        restart_clr = free_mode && !inh_q && phase_restart;
        clr_any     = clr_pulse || restart_clr;
        err         = cmp_valid && (|cmp_mismatch);
    end

    stec_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .err(err), .pause_mode(pause_mode),
        .lock_q(lock_q), .clr_any(clr_any), .cont(continue_pulse),
        .take(take), .frozen(frozen), .halt_req(halt_req)
    );

    stec_capture #(.DATA_W(DATA_W), .STR_W(STR_W), .CHK_W(CHK_W)) u_cap (
        .clk(clk), .rst_n(rst_n), .clr(clr_any), .take(take),
        .data(cmp_mismatch), .str(cmp_string), .chk(cmp_checker),
        .bits_q(err_bits), .str_q(err_string), .chk_q(err_checker)
    );

    assert_frozen_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (frozen && !clr_any) |=> $stable(err_bits) && $stable(err_checker));
    assert_restart_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (free_run && !pause_on_err && !inh_q && phase_restart) |=> (err_bits == '0));
    assert_no_capture_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmp_valid && !clr_any) |=> $stable(err_bits) && $stable(err_string));
endmodule

// File: tb/test_selftest_err_capture.sv
module test_selftest_err_capture;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_we;
    logic [2:0]  cfg_wdata;
    logic [2:0]  cfg_rdata;
    logic        free_run, pause_on_err, phase_restart, cmp_valid, continue_pulse;
    logic [63:0] cmp_mismatch;
    logic [2:0]  cmp_string;
    logic [3:0]  cmp_checker;
    logic        halt_req;
    logic [63:0] err_bits;
    logic [2:0]  err_string;
    logic [3:0]  err_checker;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    selftest_err_capture i_selftest_err_capture (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .free_run(free_run), .pause_on_err(pause_on_err),
        .phase_restart(phase_restart), .cmp_valid(cmp_valid),
        .cmp_mismatch(cmp_mismatch), .cmp_string(cmp_string),
        .cmp_checker(cmp_checker), .continue_pulse(continue_pulse),
        .halt_req(halt_req), .err_bits(err_bits), .err_string(err_string),
        .err_checker(err_checker)
    );

    typedef struct packed {
        logic        we;
        logic [2:0]  wd;
        logic        fr;
        logic        pe;
        logic        rs;
        logic        vl;
        logic        ct;
        logic [63:0] dat;
        logic [2:0]  str;
        logic [3:0]  chk;
        logic        eh;
        logic [63:0] eb;
        logic [2:0]  es;
        logic [3:0]  ec;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 34;
    // fields: we wd fr pe rs vl ct dat str chk | halt bits str chk | req
    localparam vec_t VEC [NV] = '{
        '{1'b0,3'd0,1'b0,1'b0,1'b0,1'b1,1'b0,64'h0F,  3'd1,4'h1, 1'b0,64'h0F, 3'd1,4'h1, 8'd4},  // R4
        '{1'b0,3'd0,1'b0,1'b0,1'b0,1'b0,1'b0,64'hF0,  3'd2,4'h2, 1'b0,64'h0F, 3'd1,4'h1, 8'd4},  // R4 no valid
        '{1'b0,3'd0,1'b0,1'b0,1'b0,1'b1,1'b0,64'h100, 3'd3,4'h4, 1'b0,64'h10F,3'd3,4'h5, 8'd4},  // R4 merge
        '{1'b1,3'd2,1'b0,1'b0,1'b0,1'b1,1'b0,64'h1,   3'd1,4'h1, 1'b0,64'h0,  3'd0,4'h0, 8'd3},  // R3 clear wins
        '{1'b0,3'd0,1'b1,1'b0,1'b0,1'b1,1'b0,64'hA,   3'd2,4'h8, 1'b0,64'hA,  3'd2,4'h8, 8'd5},
        '{1'b0,3'd0,1'b1,1'b0,1'b1,1'b1,1'b0,64'h5,   3'd1,4'h1, 1'b0,64'h0,  3'd0,4'h0, 8'd5},  // R5 restart wins
        '{1'b0,3'd0,1'b1,1'b0,1'b0,1'b1,1'b0,64'h30,  3'd1,4'h2, 1'b0,64'h30, 3'd1,4'h2, 8'd5},
        '{1'b0,3'd0,1'b1,1'b0,1'b1,1'b0,1'b0,64'h0,   3'd0,4'h0, 1'b0,64'h0,  3'd0,4'h0, 8'd5},  // R5
        '{1'b1,3'd4,1'b1,1'b0,1'b0,1'b0,1'b0,64'h0,   3'd0,4'h0, 1'b0,64'h0,  3'd0,4'h0, 8'd6},
        '{1'b0,3'd0,1'b1,1'b0,1'b0,1'b1,1'b0,64'h3,   3'd4,4'h1, 1'b0,64'h3,  3'd4,4'h1, 8'd6},
        '{1'b0,3'd0,1'b1,1'b0,1'b1,1'b1,1'b0,64'hC,   3'd5,4'h2, 1'b0,64'hF,  3'd5,4'h3, 8'd6},  // R6
        '{1'b0,3'd0,1'b1,1'b0,1'b1,1'b0,1'b0,64'h0,   3'd0,4'h0, 1'b0,64'hF,  3'd5,4'h3, 8'd6},  // R6
        '{1'b1,3'd2,1'b0,1'b0,1'b0,1'b0,1'b0,64'h0,   3'd0,4'h0, 1'b0,64'h0,  3'd0,4'h0, 8'd3},
        '{1'b0,3'd0,1'b0,1'b1,1'b0,1'b1,1'b0,64'h80,  3'd6,4'h4, 1'b1,64'h80, 3'd6,4'h4, 8'd7},  // R7
        '{1'b0,3'd0,1'b0,1'b1,1'b0,1'b0,1'b0,64'h0,   3'd0,4'h0, 1'b1,64'h80, 3'd6,4'h4, 8'd7},  // R7 held
        '{1'b0,3'd0,1'b0,1'b1,1'b0,1'b1,1'b0,64'h1,   3'd7,4'h1, 1'b1,64'h81, 3'd7,4'h5, 8'd8},  // R8
        '{1'b0,3'd0,1'b0,1'b1,1'b0,1'b0,1'b1,64'h0,   3'd0,4'h0, 1'b0,64'h81, 3'd7,4'h5, 8'd7},
        '{1'b0,3'd0,1'b0,1'b1,1'b0,1'b1,1'b0,64'h2,   3'd0,4'h2, 1'b1,64'h83, 3'd0,4'h7, 8'd8},  // R8
        '{1'b1,3'd2,1'b0,1'b1,1'b0,1'b0,1'b1,64'h0,   3'd0,4'h0, 1'b0,64'h0,  3'd0,4'h0, 8'd3},
        '{1'b1,3'd1,1'b0,1'b1,1'b0,1'b0,1'b0,64'h0,   3'd0,4'h0, 1'b0,64'h0,  3'd0,4'h0, 8'd9},
        '{1'b0,3'd0,1'b0,1'b1,1'b0,1'b1,1'b0,64'h4,   3'd3,4'h8, 1'b1,64'h4,  3'd3,4'h8, 8'd9},  // R9
        '{1'b0,3'd0,1'b0,1'b1,1'b0,1'b1,1'b0,64'hFF00,3'd1,4'h1, 1'b1,64'h4,  3'd3,4'h8, 8'd9},  // R9 ignored
        '{1'b0,3'd0,1'b0,1'b1,1'b0,1'b0,1'b1,64'h0,   3'd0,4'h0, 1'b0,64'h4,  3'd3,4'h8, 8'd9},
        '{1'b0,3'd0,1'b0,1'b1,1'b0,1'b1,1'b0,64'h10,  3'd2,4'h2, 1'b0,64'h4,  3'd3,4'h8, 8'd9},  // R9 no halt
        '{1'b1,3'd3,1'b0,1'b1,1'b0,1'b0,1'b0,64'h0,   3'd0,4'h0, 1'b0,64'h0,  3'd0,4'h0, 8'd9},
        '{1'b0,3'd0,1'b0,1'b1,1'b0,1'b1,1'b0,64'h20,  3'd5,4'h4, 1'b1,64'h20, 3'd5,4'h4, 8'd9},
        '{1'b1,3'd3,1'b0,1'b1,1'b0,1'b0,1'b1,64'h0,   3'd0,4'h0, 1'b0,64'h0,  3'd0,4'h0, 8'd9},
        '{1'b1,3'd1,1'b0,1'b0,1'b0,1'b1,1'b0,64'h1,   3'd1,4'h1, 1'b0,64'h1,  3'd1,4'h1, 8'd10}, // R10
        '{1'b0,3'd0,1'b0,1'b0,1'b0,1'b1,1'b0,64'h2,   3'd2,4'h2, 1'b0,64'h3,  3'd2,4'h3, 8'd10}, // R10 lock ignored
        '{1'b1,3'd4,1'b0,1'b0,1'b1,1'b0,1'b0,64'h0,   3'd0,4'h0, 1'b0,64'h3,  3'd2,4'h3, 8'd10}, // R10 restart ignored
        '{1'b1,3'd0,1'b0,1'b0,1'b0,1'b0,1'b0,64'h0,   3'd0,4'h0, 1'b0,64'h3,  3'd2,4'h3, 8'd10},
        '{1'b0,3'd0,1'b1,1'b1,1'b1,1'b0,1'b0,64'h0,   3'd0,4'h0, 1'b0,64'h3,  3'd2,4'h3, 8'd10}, // R10 pause wins
        '{1'b0,3'd0,1'b1,1'b1,1'b0,1'b1,1'b0,64'h40,  3'd0,4'h1, 1'b1,64'h43, 3'd0,4'h3, 8'd10},
        '{1'b1,3'd2,1'b0,1'b0,1'b0,1'b0,1'b1,64'h0,   3'd0,4'h0, 1'b0,64'h0,  3'd0,4'h0, 8'd3}
    };

    task automatic idle_inputs();
        cfg_we = 1'b0; cfg_wdata = '0; free_run = 1'b0; pause_on_err = 1'b0;
        phase_restart = 1'b0; cmp_valid = 1'b0; continue_pulse = 1'b0;
        cmp_mismatch = '0; cmp_string = '0; cmp_checker = '0;
    endtask

    task automatic check_outs(input int req, input logic eh, input logic [63:0] eb,
                              input logic [2:0] es, input logic [3:0] ec);
        n_run++;
        if (halt_req !== eh || err_bits !== eb || err_string !== es || err_checker !== ec) begin
            n_fail++;
            $display("FAIL R%0d: got halt=%0b bits=%h str=%0d chk=%h, expected halt=%0b bits=%h str=%0d chk=%h",
                     req, halt_req, err_bits, err_string, err_checker, eh, eb, es, ec);
        end
    endtask

    task automatic check_cfg(input int req, input logic [2:0] exp);
        n_run++;
        if (cfg_rdata !== exp) begin
            n_fail++;
            $display("FAIL R%0d: cfg_rdata got %b expected %b", req, cfg_rdata, exp);
        end
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        idle_inputs();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        check_outs(1, 1'b0, 64'h0, 3'd0, 4'h0);
        check_cfg(1, 3'b000);

        // R2: control bits readback, clear reads 0
        @(negedge clk); cfg_we = 1'b1; cfg_wdata = 3'b111;
        @(posedge clk); #1; check_cfg(2, 3'b101);
        @(negedge clk); cfg_we = 1'b1; cfg_wdata = 3'b010;
        @(posedge clk); #1; check_cfg(2, 3'b000);
        check_outs(3, 1'b0, 64'h0, 3'd0, 4'h0);

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            cfg_we = VEC[i].we; cfg_wdata = VEC[i].wd;
            free_run = VEC[i].fr; pause_on_err = VEC[i].pe;
            phase_restart = VEC[i].rs; cmp_valid = VEC[i].vl;
            continue_pulse = VEC[i].ct; cmp_mismatch = VEC[i].dat;
            cmp_string = VEC[i].str; cmp_checker = VEC[i].chk;
            @(posedge clk); #1;
            check_outs(int'(VEC[i].req), VEC[i].eh, VEC[i].eb, VEC[i].es, VEC[i].ec);
        end

        // R4: valid with zero mismatch vector is no error, even in pause mode
        @(negedge clk); idle_inputs(); pause_on_err = 1'b1; cmp_valid = 1'b1;
        cmp_string = 3'd6; cmp_checker = 4'hF;
        @(posedge clk); #1; check_outs(4, 1'b0, 64'h0, 3'd0, 4'h0);

        // R1: reset in the middle of a halt
        @(negedge clk); idle_inputs(); pause_on_err = 1'b1; cmp_valid = 1'b1;
        cmp_mismatch = 64'h8000_0000_0000_0000; cmp_string = 3'd2; cmp_checker = 4'h2;
        @(posedge clk); #1; check_outs(7, 1'b1, 64'h8000_0000_0000_0000, 3'd2, 4'h2);
        @(negedge clk); idle_inputs(); rst_n = 1'b0;
        @(posedge clk); #1; check_outs(1, 1'b0, 64'h0, 3'd0, 4'h0);
        @(negedge clk); rst_n = 1'b1;

        idle_inputs();
        repeat (2) @(posedge clk);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule